// File: doc/BRIEF.md
# Six-Channel PWM DAC Bank

The bank drives six pulse-width-modulated outputs. A small low-pass filter outside the chip turns each one into an analog level. Each channel takes its duty from an 8-bit register on a byte-wide register bus. All channels compare against one shared period counter, so every waveform starts its high phase on the same clock. An option register sets two things: how fast the counter advances (every second clock, or every clock) and the period length (256 or 253 steps). The 253-step period allows a truly constant-high output. The 256-step period always leaves at least one low step.

A per-pin routing bit chooses what each pin carries: the PWM waveform, or a plain output bit taken from a data register. A new duty value is held in a per-channel shadow and takes effect only when the next period begins. This keeps a mid-period write from clipping or stretching a pulse. All registers read back through the same bus.

Top module: `pwm_dac_bank`

## Requirements
- R1: Duty registers for channels 0..5 sit at addresses 0x20..0x25. Each reads back the value last written and resets to 0x80.
- R2: In PWM mode, a pin is high while the period counter is below the channel's active duty. At the normal rate the counter advances every second clock, so the high time per 512-clock period is 2 x duty clocks.
- R3: When option bit 1 (short period) is set, the counter wraps after step 252, giving a 253-step period. Duty codes 0xFD, 0xFE and 0xFF then give a constant high output.
- R4: With a 256-step period, duty 0xFF gives a pin that is low for exactly one step in every period.
- R5: Duty 0x00 gives a constant low output in both period lengths.
- R6: When option bit 0 (fast) is set, the counter advances on every clock. This halves the period to 256 clocks (or 253 clocks with the short period).
- R7: A duty write does not change the waveform before the next period starts.
- R8: All channels share one counter. Every channel with a nonzero duty that is not full rises on the same clock.
- R9: Register 0x28 bits [5:0] select the pin source per channel: 0 routes the PWM waveform, 1 routes the matching bit of register 0x29 bits [5:0]. Both registers reset to 0 and read back in bits [5:0], with the upper bits reading 0.
- R10: Register 0x2A reads back bits [1:0] (bit 0 fast, bit 1 short), with the upper bits reading 0, and resets to 0. Addresses not listed read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register address, used for both read and write |
| reg_wdata_i | input | 8 | Write data |
| reg_we_i | input | 1 | Write strobe, one register written per clock it is high |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| pwm_pin_o | output | 6 | Pin outputs, one per channel |

## Verification
The assertions assume that register writes arrive as single-clock strobes with stable address and data. They also assume that the option bits change only between measurement windows: a switch from the long to the short period while the counter is above 252 is legal, and is covered only by the wrap check. The stimulus writes every register at a falling clock edge and then waits at least two full periods before measuring a channel. Each waveform check therefore sees settled shadow registers, and each window lasts exactly one period, so the counter phase does not matter.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int unsigned DUTY_BASE  = 32'h20;
  localparam int unsigned SRC_ADDR   = 32'h28;
  localparam int unsigned GPIO_ADDR  = 32'h29;
  localparam int unsigned OPT_ADDR   = 32'h2A;
  localparam int unsigned DUTY_RESET = 32'h80;
  localparam int unsigned SHORT_TRIM = 3;  // steps dropped from the long period
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned DW     = 8,
  parameter int unsigned AW     = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [AW-1:0]                addr_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic                         we_i,
  output logic [DW-1:0]                rdata_o,
  output logic [NUM_CH-1:0][DW-1:0]    duty_o,
  output logic [NUM_CH-1:0]            src_gpio_o,
  output logic [NUM_CH-1:0]            gpio_o,
  output logic                         fast_o,
  output logic                         short_o
);
  localparam logic [AW-1:0] SRC_A  = AW'(SRC_ADDR);
  localparam logic [AW-1:0] GPIO_A = AW'(GPIO_ADDR);
  localparam logic [AW-1:0] OPT_A  = AW'(OPT_ADDR);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_duty
    localparam logic [AW-1:0] MY_A = AW'(DUTY_BASE + c);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      duty_o[c] <= DW'(DUTY_RESET);
      else if (we_i && addr_i == MY_A)  duty_o[c] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_gpio_o <= '0;
      gpio_o     <= '0;
      fast_o     <= 1'b0;
      short_o    <= 1'b0;
    end else if (we_i) begin
      if (addr_i == SRC_A)  src_gpio_o <= wdata_i[NUM_CH-1:0];
      if (addr_i == GPIO_A) gpio_o     <= wdata_i[NUM_CH-1:0];
      if (addr_i == OPT_A) begin
        fast_o  <= wdata_i[0];
        short_o <= wdata_i[1];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == AW'(DUTY_BASE + c)) rdata_o = duty_o[c];
    end
    if (addr_i == SRC_A)  rdata_o[NUM_CH-1:0] = src_gpio_o;
    if (addr_i == GPIO_A) rdata_o[NUM_CH-1:0] = gpio_o;
    if (addr_i == OPT_A)  rdata_o[1:0] = {short_o, fast_o};
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_bank_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fast_i,
  input  logic          short_i,
  output logic [DW-1:0] cnt_o,
  output logic          tick_o,
  output logic          load_o
);
  localparam logic [DW-1:0] LAST_FULL  = {DW{1'b1}};
  localparam logic [DW-1:0] LAST_SHORT = LAST_FULL - DW'(SHORT_TRIM);

  logic          phase_q;
  logic [DW-1:0] last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  assign tick_o = fast_i | phase_q;
  assign last   = short_i ? LAST_SHORT : LAST_FULL;
  // >= so a switch to the short period above its last step still wraps
  assign load_o = tick_o && (cnt_o >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_o) cnt_o <= '0;
    else if (tick_o) cnt_o <= cnt_o + DW'(1);
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] duty_i,
  input  logic          load_i,
  input  logic [DW-1:0] cnt_i,
  input  logic          src_gpio_i,
  input  logic          gpio_i,
  output logic [DW-1:0] shadow_o,
  output logic          pin_o
);
  logic pwm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_o <= DW'(DUTY_RESET);
    else if (load_i) shadow_o <= duty_i;
  end

  assign pwm   = cnt_i < shadow_o;
  assign pin_o = src_gpio_i ? gpio_i : pwm;
endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned DW     = 8,
  parameter int unsigned AW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic              reg_we_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic [NUM_CH-1:0] pwm_pin_o
);
  logic [NUM_CH-1:0][DW-1:0] duty;
  logic [NUM_CH-1:0]         src_gpio;
  logic [NUM_CH-1:0]         gpio;
  logic                      fast;
  logic                      short_per;
  logic [DW-1:0]             cnt;
  logic                      tick;
  logic                      load;
  logic [NUM_CH*DW-1:0]      shadow_flat;

  pwm_regs #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .we_i       (reg_we_i),
    .rdata_o    (reg_rdata_o),
    .duty_o     (duty),
    .src_gpio_o (src_gpio),
    .gpio_o     (gpio),
    .fast_o     (fast),
    .short_o    (short_per)
  );

  pwm_timebase #(.DW(DW)) u_tb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fast_i  (fast),
    .short_i (short_per),
    .cnt_o   (cnt),
    .tick_o  (tick),
    .load_o  (load)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel #(.DW(DW)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .duty_i     (duty[c]),
      .load_i     (load),
      .cnt_i      (cnt),
      .src_gpio_i (src_gpio[c]),
      .gpio_i     (gpio[c]),
      .shadow_o   (shadow_flat[c*DW +: DW]),
      .pin_o      (pwm_pin_o[c])
    );
  end
endmodule

// File: rtl/pwm_dac_bank_chk.sv
module pwm_dac_bank_chk #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned DW     = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [DW-1:0]        cnt_i,
  input logic                 tick_i,
  input logic                 load_i,
  input logic                 fast_i,
  input logic                 short_i,
  input logic [NUM_CH*DW-1:0] shadow_i,
  input logic [NUM_CH-1:0]    src_gpio_i,
  input logic [NUM_CH-1:0]    gpio_i,
  input logic [NUM_CH-1:0]    pin_i
);
  localparam logic [DW-1:0] LAST_FULL  = {DW{1'b1}};
  localparam logic [DW-1:0] LAST_SHORT = LAST_FULL - DW'(3);

  // R2: counter restarts at zero after a period boundary
  a_r2_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_i == '0));

  // R2: counter steps by one inside a period
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> (cnt_i == $past(cnt_i) + DW'(1)));

  // R6: normal rate never advances on two clocks in a row
  a_r6_half_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fast_i && tick_i) |=> (fast_i || !tick_i));

  // R3: short period ends at its last step
  a_r3_short_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_i && tick_i && cnt_i == LAST_SHORT) |-> load_i);

  // R7: active duties change only at a period boundary
  a_r7_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(shadow_i));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pin
    a_r9_gpio_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_gpio_i[c] |-> (pin_i[c] == gpio_i[c]));

    a_r5_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!src_gpio_i[c] && shadow_i[c*DW +: DW] == '0) |-> !pin_i[c]);

    a_r3_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!src_gpio_i[c] && short_i && shadow_i[c*DW +: DW] > LAST_SHORT
       && cnt_i <= LAST_SHORT) |-> pin_i[c]);

    a_r4_ff_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!src_gpio_i[c] && !short_i && cnt_i == LAST_FULL) |-> !pin_i[c]);
  end
endmodule

bind pwm_dac_bank pwm_dac_bank_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_i      (cnt),
  .tick_i     (tick),
  .load_i     (load),
  .fast_i     (fast),
  .short_i    (short_per),
  .shadow_i   (shadow_flat),
  .src_gpio_i (src_gpio),
  .gpio_i     (gpio),
  .pin_i      (pwm_pin_o)
);

// File: tb/pwm_dac_bank_test.sv
`timescale 1ns/1ps
module pwm_dac_bank_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_rdata_o;
  logic [5:0] pwm_pin_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  pwm_dac_bank uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_we_i(reg_we_i),
    .reg_rdata_o(reg_rdata_o), .pwm_pin_o(pwm_pin_o));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic meas(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); #2;
      if (pwm_pin_o[ch]) hi++;
    end
  endtask

  task automatic settle;
    repeat (1100) @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [7:0] d; int hi;
    for (int c = 0; c < 6; c++) begin
      rd(8'h20 + 8'(c), d); check("R1 duty reset", d, 8'h80);
    end
    rd(8'h28, d); check("R9 source reset", d, 0);
    rd(8'h29, d); check("R9 gpio reset", d, 0);
    rd(8'h2A, d); check("R10 option reset", d, 0);
    meas(3, 512, hi); check("R2 mid-scale high time", hi, 256);
  endtask

  task automatic t_normal;
    logic [7:0] duties [6] = '{8'h00, 8'h01, 8'h40, 8'hA5, 8'hFE, 8'hFF};
    logic [7:0] d; int hi;
    for (int c = 0; c < 6; c++) wr(8'h20 + 8'(c), duties[c]);
    for (int c = 0; c < 6; c++) begin
      rd(8'h20 + 8'(c), d); check("R1 duty readback", d, duties[c]);
    end
    settle();
    meas(0, 512, hi); check("R5 zero duty low", hi, 0);
    meas(1, 512, hi); check("R2 duty 01", hi, 2);
    meas(2, 512, hi); check("R2 duty 40", hi, 128);
    meas(3, 512, hi); check("R2 duty A5", hi, 330);
    meas(4, 512, hi); check("R2 duty FE", hi, 508);
    meas(5, 512, hi); check("R4 duty FF gap", hi, 510);
  endtask

  task automatic t_fast;
    int hi;
    wr(8'h2A, 8'h01); settle();
    meas(2, 256, hi); check("R6 fast duty 40", hi, 64);
    meas(5, 256, hi); check("R6 R4 fast duty FF", hi, 255);
    meas(0, 256, hi); check("R5 fast zero low", hi, 0);
  endtask

  task automatic t_short;
    int hi;
    wr(8'h23, 8'hFD); wr(8'h24, 8'hFE); wr(8'h25, 8'hFF);
    wr(8'h2A, 8'h02); settle();
    meas(3, 506, hi); check("R3 FD constant high", hi, 506);
    meas(4, 506, hi); check("R3 FE constant high", hi, 506);
    meas(5, 506, hi); check("R3 FF constant high", hi, 506);
    meas(2, 506, hi); check("R3 short duty 40", hi, 128);
    meas(0, 506, hi); check("R5 short zero low", hi, 0);
    wr(8'h2A, 8'h03); settle();
    meas(5, 253, hi); check("R3 R6 fast short FF", hi, 253);
    meas(2, 253, hi); check("R3 R6 fast short 40", hi, 64);
    wr(8'h2A, 8'h00);
  endtask

  task automatic t_align;
    logic [7:0] duties [6] = '{8'd10, 8'd40, 8'd90, 8'd200, 8'd250, 8'd20};
    logic [5:0] prev; int rises0, skew;
    for (int c = 0; c < 6; c++) wr(8'h20 + 8'(c), duties[c]);
    settle();
    rises0 = 0; skew = 0;
    @(negedge clk_i); #2 prev = pwm_pin_o;
    for (int i = 0; i < 1024; i++) begin
      logic [5:0] now, rise;
      @(negedge clk_i); #2 now = pwm_pin_o;
      rise = now & ~prev;
      if (rise[0]) rises0++;
      if (rise != 6'b000000 && rise != 6'b111111) skew++;
      prev = now;
    end
    check("R8 rises per two periods", rises0, 2);
    check("R8 misaligned rises", skew, 0);
  endtask

  task automatic t_deferred;
    logic p0, p1, n0, n1; int first, idx, ok1;
    wr(8'h20, 8'h00); wr(8'h21, 8'd100); settle();
    idx = 0;
    @(negedge clk_i); #2 p1 = pwm_pin_o[1];
    forever begin
      @(negedge clk_i); #2 n1 = pwm_pin_o[1];
      idx++;
      if ((n1 && !p1) || idx > 1200) break;
      p1 = n1;
    end
    repeat (300) @(negedge clk_i);
    wr(8'h20, 8'hFF);
    first = -1; ok1 = 0;
    #2 p0 = pwm_pin_o[0]; p1 = pwm_pin_o[1];
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk_i); #2 n0 = pwm_pin_o[0]; n1 = pwm_pin_o[1];
      if (n0 && !p0 && first < 0) begin
        first = i;
        ok1 = (n1 && !p1) ? 1 : 0;
      end
      p0 = n0; p1 = n1;
    end
    check("R7 no change mid-period", (first >= 50) ? 1 : 0, 1);
    check("R7 takes effect at period start", ok1, 1);
  endtask

  task automatic t_gpio;
    logic [7:0] d;
    for (int c = 0; c < 6; c++) wr(8'h20 + 8'(c), 8'h00);
    settle();
    wr(8'h28, 8'h15); wr(8'h29, 8'h05);
    @(negedge clk_i); #2 check("R9 gpio routed", pwm_pin_o, 6'b000101);
    wr(8'h29, 8'hFF);
    @(negedge clk_i); #2 check("R9 only selected pins", pwm_pin_o, 6'b010101);
    rd(8'h28, d); check("R9 source readback", d, 8'h15);
    rd(8'h29, d); check("R9 gpio readback", d, 8'h3F);
    wr(8'h28, 8'h00);
    @(negedge clk_i); #2 check("R9 back to PWM", pwm_pin_o, 6'b000000);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    wr(8'h22, 8'h5A);
    wr(8'h26, 8'hFF); wr(8'h2B, 8'hFF); wr(8'h1F, 8'hFF);
    rd(8'h26, d); check("R10 unmapped 26 reads 0", d, 0);
    rd(8'h2B, d); check("R10 unmapped 2B reads 0", d, 0);
    rd(8'h22, d); check("R10 duty untouched", d, 8'h5A);
    rd(8'h28, d); check("R10 source untouched", d, 0);
    rd(8'h2A, d); check("R10 option untouched", d, 0);
    wr(8'h2A, 8'hFF);
    rd(8'h2A, d); check("R10 option masked", d, 3);
    wr(8'h2A, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_normal();
    t_fast();
    t_short();
    t_align();
    t_deferred();
    t_gpio();
    t_unmapped();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule